// File: doc/BRIEF.md
# HDLC Frame Receiver with Station Address Filter

This block recovers bit-oriented synchronous frames from a serial line that has already been decoded to plain bits. A one-cycle bit enable marks each line bit. After reset the receiver hunts for an opening flag (a zero, six ones, a zero). When it finds one it pulses a sync output. It then removes the zeros that the sender stuffed after five ones, assembles characters least significant bit first, and runs a bit-serial CRC over every frame bit, including the frame check sequence.

The first character of a frame is the station address. A frame goes through if that address equals the programmed address, equals the all-ones broadcast address, or, when nibble matching is on, equals the programmed address in its upper four bits. Any other frame produces no output at all. Accepted characters come out as a byte stream. The last two characters are held back, because they are the check sequence, so the byte stream carries the address and the information field only. The last of these bytes carries an end marker. At every closing flag or abort a status word reports the CRC verdict, an abort, a short frame and the count of leftover bits. An interrupt request pulse follows the selected mode.

Top module: `hdlc_rx`

## Requirements
- R1: After reset all outputs are low and the receiver is in hunt mode: no byte, status or sync is produced until an opening flag has been seen.
- R2: `sync_pulse` is high for exactly one cycle when a flag ends the hunt, and it is not pulsed for later flags while the receiver stays synchronized.
- R3: Inside a frame, a zero received after five consecutive ones is deleted before character assembly, so stuffed payloads are delivered unchanged.
- R4: A frame is accepted when its first byte equals `station_addr`, equals 0xFF, or, with `nibble_match` high, matches `station_addr` in bits [7:4]. Any other frame produces no `rx_valid` and no `frame_status_valid`.
- R5: CRC uses the polynomial x^16+x^12+x^5+1, shifted in wire order. A frame is correct when the register holds 0x1D0F after all bits up to the closing flag. Otherwise `frame_status` bit 0 is set.
- R6: Seven consecutive ones abort a started frame. The held bytes are discarded, a status with bit 1 set is issued, and the receiver returns to hunt, so the next flag pulses `sync_pulse` again.
- R7: The last two characters before the closing flag are never delivered. The address and information bytes appear in order on `rx_data`, with `rx_last` high only on the final one.
- R8: A frame of fewer than three characters delivers no bytes and reports status bit 2.
- R9: `irq_mode` selects the interrupt source: 0 gives none, 1 pulses on the first delivered byte of a frame, 2 pulses on every delivered byte, and 3 pulses with each status word.
- R10: `frame_status` bits [5:3] give the number of bits left over after the last whole character when the closing flag arrives.
- R11: `crc_preset_ones` selects whether the CRC register starts each frame at all ones (1) or all zeros (0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Marks a cycle that carries a line bit |
| bit_in | input | 1 | Line bit, valid with bit_en |
| station_addr | input | 8 | Programmed station address |
| nibble_match | input | 1 | Compare only the upper four address bits |
| crc_preset_ones | input | 1 | CRC start value: 1 all ones, 0 all zeros |
| irq_mode | input | 2 | Interrupt source select |
| rx_valid | output | 1 | A received byte is on rx_data |
| rx_data | output | 8 | Received byte |
| rx_last | output | 1 | Final delivered byte of the frame |
| sync_pulse | output | 1 | Synchronization acquired |
| frame_status_valid | output | 1 | frame_status is valid this cycle |
| frame_status | output | 6 | {leftover bits[2:0], short, abort, crc error} |
| irq_pulse | output | 1 | Interrupt request pulse |

## Verification
The bench builds the receiver with its default parameters: 8-bit characters, a 16-bit check sequence, a six-ones flag and the 0xFF broadcast address. With these values the hold-back depth is three bytes. The short-frame boundary is therefore reached with a two-character frame, and the path where only the address is delivered is reached with a frame that has an empty information field. Payloads full of 0xFF and 0x7E exercise zero deletion directly, appended odd bits reach every value of the leftover field, and streams of raw ones reach the abort.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_OPEN = 2'd1,
        ST_SKIP = 2'd2
    } rx_state_e;

    typedef enum logic [1:0] {
        IRQ_OFF     = 2'd0,
        IRQ_FIRST   = 2'd1,
        IRQ_EVERY   = 2'd2,
        IRQ_SPECIAL = 2'd3
    } irq_mode_e;

    // status word field positions
    localparam int SW_CRC     = 0;
    localparam int SW_ABORT   = 1;
    localparam int SW_SHORT   = 2;
    localparam int SW_RES_LSB = 3;

endpackage

// File: rtl/hdlc_rx_deframe.sv
// Flag/abort detection, zero deletion and a short bit delay that keeps
// the leading part of a closing flag out of the data stream.
module hdlc_rx_deframe #(
    parameter int FLAG_ONES = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic bit_in,
    output logic flag_o,
    output logic abort_o,
    output logic dvalid_o,
    output logic dbit_o
);
    localparam int DLY    = FLAG_ONES;
    localparam int ONES_W = $clog2(FLAG_ONES + 2);
    localparam int FILL_W = $clog2(DLY + 1);
    localparam logic [ONES_W-1:0] ONES_MAX = ONES_W'(FLAG_ONES + 1);

    typedef struct packed {
        logic [ONES_W-1:0] ones;
        logic [DLY-1:0]    dly;
        logic [FILL_W-1:0] fill;
    } df_t;

    df_t q, d;

    always_comb begin
        d        = q;
        flag_o   = 1'b0;
        abort_o  = 1'b0;
        dvalid_o = 1'b0;
        dbit_o   = q.dly[0];
        if (bit_en) begin
            if (bit_in)
                d.ones = (q.ones == ONES_MAX) ? q.ones : q.ones + 1'b1;
            else
                d.ones = '0;
            flag_o  = !bit_in && (q.ones == ONES_W'(FLAG_ONES));
            abort_o =  bit_in && (q.ones == ONES_W'(FLAG_ONES));
            if (flag_o || abort_o) begin
                d.fill = '0;
            end else if (q.ones < ONES_W'(FLAG_ONES - 1)) begin
                if (q.fill == FILL_W'(DLY)) begin
                    dvalid_o = 1'b1;
                    dbit_o   = q.dly[0];
                    d.dly    = {bit_in, q.dly[DLY-1:1]};
                end else begin
                    d.dly[q.fill] = bit_in;
                    d.fill        = q.fill + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R3: a flag empties the delay line so flag bits never become data
    p_flush_on_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        flag_o |=> (q.fill == '0));

    // R6: during a run of ones past the flag length nothing is emitted
    p_abort_no_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_o && bit_en) |=> !(dvalid_o && bit_en && bit_in));

endmodule

// File: rtl/hdlc_rx_crc.sv
// One bit-serial CRC step, shift-left form.
module hdlc_rx_crc #(
    parameter int              W    = 16,
    parameter logic [W-1:0]    POLY = 16'h1021
) (
    input  logic [W-1:0] crc_i,
    input  logic         din,
    output logic [W-1:0] crc_o
);
    logic fb;
    assign fb    = crc_i[W-1] ^ din;
    assign crc_o = {crc_i[W-2:0], 1'b0} ^ (fb ? POLY : '0);
endmodule

// File: rtl/hdlc_rx_addr.sv
module hdlc_rx_addr #(
    parameter int               BYTE_W = 8,
    parameter logic [BYTE_W-1:0] BCAST = 8'hFF
) (
    input  logic [BYTE_W-1:0] byte_i,
    input  logic [BYTE_W-1:0] addr_i,
    input  logic              nibble_i,
    output logic              hit_o
);
    localparam int HI = BYTE_W / 2;
    always_comb begin
        hit_o = (byte_i == addr_i) || (byte_i == BCAST) ||
                (nibble_i && (byte_i[BYTE_W-1:HI] == addr_i[BYTE_W-1:HI]));
    end
endmodule

// File: rtl/hdlc_rx.sv
module hdlc_rx
    import hdlc_rx_pkg::*;
#(
    parameter int                 BYTE_W      = 8,
    parameter int                 CRC_W       = 16,
    parameter logic [CRC_W-1:0]   CRC_POLY    = 16'h1021,
    parameter logic [CRC_W-1:0]   CRC_RESIDUE = 16'h1D0F,
    parameter logic [BYTE_W-1:0]  BCAST_ADDR  = 8'hFF,
    parameter int                 FLAG_ONES   = 6
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic                                     bit_en,
    input  logic                                     bit_in,
    input  logic [BYTE_W-1:0]                        station_addr,
    input  logic                                     nibble_match,
    input  logic                                     crc_preset_ones,
    input  logic [1:0]                               irq_mode,
    output logic                                     rx_valid,
    output logic [BYTE_W-1:0]                        rx_data,
    output logic                                     rx_last,
    output logic                                     sync_pulse,
    output logic                                     frame_status_valid,
    output logic [SW_RES_LSB+$clog2(BYTE_W)-1:0]     frame_status,
    output logic                                     irq_pulse
);
    localparam int BIT_W     = $clog2(BYTE_W);
    localparam int STAT_W    = SW_RES_LSB + BIT_W;
    localparam int FCS_BYTES = CRC_W / BYTE_W;
    localparam int HOLD      = FCS_BYTES + 1;
    localparam int CNT_W     = $clog2(HOLD + 1);

    typedef struct packed {
        rx_state_e                    st;
        logic [BIT_W-1:0]             bitcnt;
        logic [BYTE_W-1:0]            sh;
        logic [CNT_W-1:0]             nbytes;
        logic [HOLD-1:0][BYTE_W-1:0]  hold;
        logic [CRC_W-1:0]             crc;
        logic                         first_done;
        logic                         ov;
        logic [BYTE_W-1:0]            od;
        logic                         ol;
        logic                         sy;
        logic                         sv;
        logic [STAT_W-1:0]            sw;
        logic                         irq;
    } rx_t;

    rx_t q, d;

    logic flag, abort, dvalid, dbit;
    logic [CRC_W-1:0]  crc_step;
    logic [BYTE_W-1:0] new_byte;
    logic              addr_hit;

    hdlc_rx_deframe #(.FLAG_ONES(FLAG_ONES)) u_deframe (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
        .flag_o(flag), .abort_o(abort), .dvalid_o(dvalid), .dbit_o(dbit)
    );

    hdlc_rx_crc #(.W(CRC_W), .POLY(CRC_POLY)) u_crc (
        .crc_i(q.crc), .din(dbit), .crc_o(crc_step)
    );

    assign new_byte = {dbit, q.sh[BYTE_W-1:1]};

    hdlc_rx_addr #(.BYTE_W(BYTE_W), .BCAST(BCAST_ADDR)) u_addr (
        .byte_i(new_byte), .addr_i(station_addr), .nibble_i(nibble_match),
        .hit_o(addr_hit)
    );

    logic has_content, do_emit, emit_last;

    always_comb begin
        d           = q;
        d.ov        = 1'b0;
        d.ol        = 1'b0;
        d.sy        = 1'b0;
        d.sv        = 1'b0;
        d.irq       = 1'b0;
        do_emit     = 1'b0;
        emit_last   = 1'b0;
        has_content = (q.nbytes != '0) || (q.bitcnt != '0);

        if (abort) begin
            if (q.st == ST_OPEN && has_content) begin
                d.sv                          = 1'b1;
                d.sw                          = '0;
                d.sw[SW_ABORT]                = 1'b1;
                d.sw[SW_RES_LSB +: BIT_W]     = q.bitcnt;
            end
            d.st = ST_HUNT;
        end else if (flag) begin
            if (q.st == ST_HUNT) begin
                d.sy = 1'b1;
            end else if (q.st == ST_OPEN && has_content) begin
                d.sv                      = 1'b1;
                d.sw                      = '0;
                d.sw[SW_RES_LSB +: BIT_W] = q.bitcnt;
                if (q.nbytes < CNT_W'(HOLD)) begin
                    d.sw[SW_SHORT] = 1'b1;
                end else begin
                    do_emit        = 1'b1;
                    emit_last      = 1'b1;
                    d.sw[SW_CRC]   = (q.crc != CRC_RESIDUE);
                end
            end
            d.st = ST_OPEN;
        end else if (dvalid && q.st == ST_OPEN) begin
            d.crc    = crc_step;
            d.sh     = new_byte;
            d.bitcnt = q.bitcnt + 1'b1;
            if (q.bitcnt == BIT_W'(BYTE_W - 1)) begin
                if (q.nbytes == '0 && !addr_hit) begin
                    d.st = ST_SKIP;
                end else if (q.nbytes == CNT_W'(HOLD)) begin
                    do_emit = 1'b1;
                    for (int i = 0; i < HOLD - 1; i++) d.hold[i] = q.hold[i+1];
                    d.hold[HOLD-1] = new_byte;
                end else begin
                    d.hold[q.nbytes] = new_byte;
                    d.nbytes         = q.nbytes + 1'b1;
                end
            end
        end

        // new frame context after any flag or abort
        if (abort || flag) begin
            d.bitcnt     = '0;
            d.nbytes     = '0;
            d.crc        = crc_preset_ones ? '1 : '0;
            d.first_done = 1'b0;
        end

        if (do_emit) begin
            d.ov = 1'b1;
            d.od = q.hold[0];
            d.ol = emit_last;
            if (irq_mode == IRQ_EVERY || (irq_mode == IRQ_FIRST && !q.first_done))
                d.irq = 1'b1;
            if (!emit_last) d.first_done = 1'b1;
        end
        if (d.sv && irq_mode == IRQ_SPECIAL) d.irq = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q     <= '0;
            q.st  <= ST_HUNT;
            q.crc <= '1;
        end else begin
            q <= d;
        end
    end

    assign rx_valid           = q.ov;
    assign rx_data            = q.od;
    assign rx_last            = q.ol;
    assign sync_pulse         = q.sy;
    assign frame_status_valid = q.sv;
    assign frame_status       = q.sw;
    assign irq_pulse          = q.irq;

    // R7: the end marker only rides on a delivered byte
    p_last_with_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        q.ol |-> q.ov);

    // R2: sync only comes out of the hunt state
    p_sync_from_hunt_r2: assert property (@(posedge clk) disable iff (!rst_n)
        q.sy |-> ($past(q.st) == ST_HUNT && q.st == ST_OPEN));

    // R6: an abort status leaves the receiver hunting
    p_abort_to_hunt_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.sv && q.sw[SW_ABORT]) |-> (q.st == ST_HUNT));

    // R8: a short frame never delivers a byte
    p_short_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.sv && q.sw[SW_SHORT]) |-> !q.ov);

    // R9: interrupt source follows the selected mode
    p_irq_every_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.irq && $past(irq_mode) == IRQ_EVERY) |-> q.ov);
    p_irq_special_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(irq_mode) == IRQ_SPECIAL) |-> (q.irq == q.sv));
    p_irq_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(irq_mode) == IRQ_OFF) |-> !q.irq);

endmodule

// File: tb/hdlc_rx_tb.sv
module hdlc_rx_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       bit_en, bit_in;
    logic [7:0] cfg_addr;
    logic       cfg_nibble, cfg_preset;
    logic [1:0] cfg_mode;
    logic       rx_valid, rx_last, sync_pulse, st_valid, irq_pulse;
    logic [7:0] rx_data;
    logic [5:0] st_word;

    always #4 clk = ~clk;

    hdlc_rx u_dut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
        .station_addr(cfg_addr), .nibble_match(cfg_nibble),
        .crc_preset_ones(cfg_preset), .irq_mode(cfg_mode),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
        .sync_pulse(sync_pulse), .frame_status_valid(st_valid),
        .frame_status(st_word), .irq_pulse(irq_pulse)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [7:0] rxq[$];
    int         last_n, last_pos, stat_n, sync_n, irq_n;
    logic [5:0] stat_last;

    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid) begin
                rxq.push_back(rx_data);
                if (rx_last) begin last_n++; last_pos = rxq.size(); end
            end
            if (st_valid) begin stat_n++; stat_last = st_word; end
            if (sync_pulse) sync_n++;
            if (irq_pulse) irq_n++;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] crc_bit(input logic [15:0] c, input logic b);
        logic fb;
        fb = c[15] ^ b;
        return fb ? ({c[14:0], 1'b0} ^ 16'h1021) : {c[14:0], 1'b0};
    endfunction

    int tx_ones = 0;

    task automatic send_raw(input logic b);
        @(negedge clk);
        bit_in = b; bit_en = 1'b1;
        @(negedge clk);
        bit_en = 1'b0;
        repeat ($urandom_range(0, 2)) @(negedge clk);
    endtask

    task automatic send_stuffed(input logic b);
        send_raw(b);
        if (b) begin
            tx_ones++;
            if (tx_ones == 5) begin send_raw(1'b0); tx_ones = 0; end
        end else tx_ones = 0;
    endtask

    task automatic send_flag();
        send_raw(1'b0);
        repeat (6) send_raw(1'b1);
        send_raw(1'b0);
        tx_ones = 0;
    endtask

    task automatic send_body(input logic [7:0] fr[$], output logic [15:0] c_out,
                             input logic preset);
        logic [15:0] c;
        c = preset ? 16'hFFFF : 16'h0000;
        foreach (fr[k])
            for (int i = 0; i < 8; i++) begin
                c = crc_bit(c, fr[k][i]);
                send_stuffed(fr[k][i]);
            end
        c_out = c;
    endtask

    task automatic send_frame(input logic [7:0] fr[$], input logic preset,
                              input bit bad, input int extra);
        logic [15:0] c, fcs;
        send_flag();
        send_body(fr, c, preset);
        fcs = ~c;
        if (bad) fcs = fcs ^ 16'h0100;
        for (int i = 15; i >= 0; i--) send_stuffed(fcs[i]);
        for (int i = 0; i < extra; i++) send_stuffed(1'b0);
        send_flag();
        repeat (6) @(negedge clk);
    endtask

    task automatic clear_mon();
        rxq.delete();
        last_n = 0; last_pos = 0; stat_n = 0; sync_n = 0; irq_n = 0;
        stat_last = '0;
    endtask

    task automatic run_frame(input logic [7:0] fr[$], input logic tx_preset,
                             input bit bad, input bit acc, input string req);
        int exp_irq;
        clear_mon();
        send_frame(fr, tx_preset, bad, 0);
        if (!acc) begin
            check(rxq.size() == 0, "R4", "bytes from filtered frame", rxq.size(), 0);
            check(stat_n == 0, "R4", "status from filtered frame", stat_n, 0);
            check(irq_n == 0, "R9", "irq from filtered frame", irq_n, 0);
            return;
        end
        check(rxq.size() == fr.size(), req, "delivered byte count", rxq.size(), fr.size());
        for (int k = 0; k < fr.size() && k < rxq.size(); k++)
            check(rxq[k] == fr[k], req, "delivered byte value", rxq[k], fr[k]);
        check(last_n == 1 && last_pos == fr.size(), "R7", "end marker position",
              last_pos, fr.size());
        check(stat_n == 1, "R5", "status count", stat_n, 1);
        check(stat_last == {5'd0, bad}, "R5", "status word", stat_last, {5'd0, bad});
        case (cfg_mode)
            2'd0:    exp_irq = 0;
            2'd1:    exp_irq = 1;
            2'd2:    exp_irq = fr.size();
            default: exp_irq = 1;
        endcase
        check(irq_n == exp_irq, "R9", "irq count", irq_n, exp_irq);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] fr[$];
        int unsigned seed_r;
        seed_r = $urandom(32'h5EED);
        rst_n = 1'b0; bit_en = 1'b0; bit_in = 1'b0;
        cfg_addr = 8'h5A; cfg_nibble = 1'b0; cfg_preset = 1'b1; cfg_mode = 2'd2;
        clear_mon();
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!rx_valid && !st_valid && !sync_pulse && !irq_pulse, "R1",
              "outputs after reset", {rx_valid, st_valid, sync_pulse, irq_pulse}, 0);

        // R1: zeros and partial ones while hunting produce nothing
        repeat (30) send_raw(1'b0);
        repeat (5) send_raw(1'b1);
        repeat (4) send_raw(1'b0);
        check(rxq.size() == 0 && stat_n == 0 && sync_n == 0, "R1",
              "activity before any flag", rxq.size() + stat_n + sync_n, 0);

        // R2: first flag pulses sync once, later flags do not
        send_flag();
        repeat (3) @(negedge clk);
        check(sync_n == 1, "R2", "sync after first flag", sync_n, 1);
        send_flag();
        send_flag();
        repeat (3) @(negedge clk);
        check(sync_n == 1, "R2", "sync after repeated flags", sync_n, 1);

        // R4/R7: exact address with ordinary payload
        fr = '{8'h5A, 8'h12, 8'h34, 8'hC3};
        run_frame(fr, 1'b1, 1'b0, 1'b1, "R7");
        check(sync_n == 0, "R2", "no sync while synchronized", sync_n, 0);

        // R3: payload dense with ones forces zero insertion
        fr = '{8'h5A, 8'hFF, 8'h7E, 8'hFF, 8'hF8, 8'h3F};
        run_frame(fr, 1'b1, 1'b0, 1'b1, "R3");

        // R4: broadcast, nibble match, nibble off, mismatch
        fr = '{8'hFF, 8'h01};
        run_frame(fr, 1'b1, 1'b0, 1'b1, "R4");
        cfg_nibble = 1'b1;
        fr = '{8'h53, 8'h99};
        run_frame(fr, 1'b1, 1'b0, 1'b1, "R4");
        cfg_nibble = 1'b0;
        run_frame(fr, 1'b1, 1'b0, 1'b0, "R4");
        fr = '{8'hA5, 8'h10, 8'h20};
        run_frame(fr, 1'b1, 1'b0, 1'b0, "R4");

        // R5: corrupted check sequence
        fr = '{8'h5A, 8'h44, 8'h55};
        run_frame(fr, 1'b1, 1'b1, 1'b1, "R5");

        // R7: address-only frame still delivers the address with the marker
        fr = '{8'h5A};
        run_frame(fr, 1'b1, 1'b0, 1'b1, "R7");

        // R11: zero preset on both sides, then a mismatch of presets
        cfg_preset = 1'b0;
        fr = '{8'h5A, 8'hE7, 8'h00};
        run_frame(fr, 1'b0, 1'b0, 1'b1, "R11");
        clear_mon();
        send_frame(fr, 1'b1, 1'b0, 0);
        check(stat_n == 1 && stat_last[0] == 1'b1, "R11", "preset mismatch crc flag",
              stat_last[0], 1);
        cfg_preset = 1'b1;

        // R8: two-character frame is short
        clear_mon();
        send_flag();
        fr = '{8'h5A, 8'h77};
        begin logic [15:0] cdummy; send_body(fr, cdummy, 1'b1); end
        send_flag();
        repeat (6) @(negedge clk);
        check(rxq.size() == 0, "R8", "bytes from short frame", rxq.size(), 0);
        check(stat_n == 1 && stat_last == 6'b000100, "R8", "short status",
              stat_last, 6'b000100);

        // R10: three leftover bits before the closing flag
        clear_mon();
        fr = '{8'h5A, 8'h21, 8'h43};
        send_frame(fr, 1'b1, 1'b0, 3);
        check(stat_n == 1 && stat_last[5:3] == 3'd3, "R10", "leftover bit count",
              stat_last[5:3], 3);
        check(rxq.size() == 3, "R10", "bytes with leftover bits", rxq.size(), 3);

        // R6: abort mid-frame drops held bytes and returns to hunt
        clear_mon();
        send_flag();
        fr = '{8'h5A, 8'h11, 8'h22};
        begin logic [15:0] cdummy; send_body(fr, cdummy, 1'b1); end
        repeat (8) send_raw(1'b1);
        repeat (6) @(negedge clk);
        check(rxq.size() == 0, "R6", "bytes after abort", rxq.size(), 0);
        check(stat_n == 1 && stat_last[1] == 1'b1, "R6", "abort status bit",
              stat_last[1], 1);
        fr = '{8'h5A, 8'h66};
        clear_mon();
        send_frame(fr, 1'b1, 1'b0, 0);
        check(sync_n == 1, "R6", "sync after abort re-hunt", sync_n, 1);
        check(rxq.size() == 2, "R6", "frame after abort", rxq.size(), 2);

        // R9: each interrupt mode
        for (int m = 0; m < 4; m++) begin
            cfg_mode = 2'(m);
            fr = '{8'h5A, 8'h0F, 8'hF0, 8'h81};
            run_frame(fr, 1'b1, 1'b0, 1'b1, "R9");
        end

        // random frames
        for (int n = 0; n < 24; n++) begin
            int  len, sel;
            bit  bad;
            cfg_mode = 2'($urandom_range(0, 3));
            sel = $urandom_range(0, 2);
            bad = ($urandom_range(0, 3) == 0);
            len = $urandom_range(1, 6);
            fr.delete();
            fr.push_back(sel == 0 ? 8'h5A : (sel == 1 ? 8'hFF : 8'h4A));
            for (int k = 0; k < len; k++) fr.push_back(8'($urandom));
            run_frame(fr, 1'b1, bad, sel != 2, "R4");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule